// File: doc/BRIEF.md
# Byte Register Access Target for a Two-Wire Serial Bus

This block lets a host on a two-wire serial bus (I2C) read and write a byte-wide register map. It is a target only. SCL and SDA are sampled by the block's own system clock and pass through a two-flop synchronizer and a short glitch filter. The block then finds START, repeated START and STOP conditions and decodes the device address. It answers on SDA through an open-drain enable: when `sda_oe` is 1 the pad pulls low, and otherwise the pad is released. All timing comes from the oversampling clock, so the bus keeps working while any video or pixel clock is stopped.

Reads and writes are told apart by two separate 8-bit device addresses. Bit 1 of both addresses comes from a strap input. An 8-bit sub-address pointer selects the register. The host loads it with the first byte after the write address, and it steps by one after every data byte. The pointer keeps its value across STOP, so a host first sets it with a short write and then reads from it in a separate transaction. The register storage sits outside the block. The block only drives an address, write data and a one-cycle write strobe, and it takes read data back combinationally. The top of the map is read-only: bytes sent to those addresses are accepted on the bus and then dropped.

Top module: `i2c_reg_target`

## Requirements
- R1: The write address is 0x40 with `addr_sel`=0 and 0x42 with `addr_sel`=1. The read address is 0x41 or 0x43 for the same strap values: bit 0 set means read, and bit 1 equals the strap. Either address is acknowledged, meaning SDA is held low for the whole high phase of the ninth SCL clock.
- R2: A device address byte that matches neither address is not acknowledged, so SDA stays high in the ninth clock. After that the block produces no write strobe and never pulls SDA low until the next START.
- R3: In a write transaction, the byte after the address loads the pointer. Every following data byte is acknowledged and gives exactly one one-cycle `reg_we` pulse, with `reg_addr` equal to the sub-address plus the byte index and `reg_wdata` equal to the byte.
- R4: The pointer increases by one after each data byte, whether written or sent, and wraps from 0xFF to 0x00.
- R5: The pointer is kept across STOP. A read transaction with no preceding sub-address starts where the last transaction left the pointer.
- R6: In a read transaction the block sends `reg_rdata` at the pointer, MSB first, one bit per SCL clock. A master ACK asks for the next byte. A master NACK ends the transfer, and SDA is released.
- R7: Addresses 0xF0 to 0xFF are read-only. A data byte written there is still acknowledged and the pointer still advances, but no `reg_we` pulse is produced, and those registers read back unchanged.
- R8: A START or STOP seen at any point abandons the byte in progress and releases SDA. A data byte cut short this way writes nothing. A repeated START with the read address, without a STOP in between, reads from the pointer just loaded.
- R9: `sda_oe` changes only in the cycle after a detected SCL falling edge, START or STOP, and it is never asserted while SCL is high.
- R10: After reset `sda_oe` is 0, `reg_we` is 0 and `reg_addr` is 0x00.
- R11: A pulse on SCL or SDA that lasts fewer than three system-clock cycles is filtered out and does not disturb the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL pad input |
| sda_i | input | 1 | SDA pad input (the wired bus level) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_sel | input | 1 | Strap that supplies bit 1 of both device addresses |
| reg_addr | output | 8 | Register pointer, used for both reads and writes |
| reg_wdata | output | 8 | Byte to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register content at `reg_addr`, returned combinationally |

## Verification
Any bus edge reaches the FSM six system-clock cycles after it appears on a pin: two cycles in the synchronizer, three in the filter, and one in the FSM register. An acknowledge or a new read bit therefore appears on SDA six cycles after the SCL fall that triggers it. The write strobe fires in that same cycle, and the pointer moves one cycle later. The bench master holds SCL low for at least 24 cycles before each rise and samples SDA in the middle of the 16-cycle high phase, well after any of these results have settled. The register model in the bench records each strobe at the clock edge where it is high.

// File: rtl/i2c_reg_target_pkg.sv
`timescale 1ns/1ps
package i2c_reg_target_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // bus free or not addressed yet
    ST_RX,     // shifting a byte in from the master
    ST_ACK,    // holding SDA low through the ninth clock
    ST_TX,     // shifting a register byte out
    ST_MACK,   // sampling the master's ACK or NACK
    ST_SKIP    // not addressed, wait for START
  } tgt_state_e;

  typedef enum logic [1:0] {
    RX_DEV,
    RX_SUB,
    RX_DATA
  } rx_kind_e;

  // Device address: upper six bits fixed, bit 1 from the strap, bit 0 = read.
  function automatic logic [7:0] dev_addr(input logic [5:0] hi, input logic strap,
                                          input logic rd);
    return {hi, strap, rd};
  endfunction

  function automatic logic is_read_only(input logic [7:0] addr, input logic [7:0] lo);
    return addr >= lo;
  endfunction

endpackage

// File: rtl/i2c_glitch_filter.sv
`timescale 1ns/1ps
module i2c_glitch_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      run_q  <= '0;
      level  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw};
      if (sync_q[1] == level) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_LEN - 1)) begin
        level <= sync_q[1];
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_bus_events.sv
`timescale 1ns/1ps
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  // SDA moving while SCL stays high marks a bus condition.
  assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2c_target_fsm.sv
`timescale 1ns/1ps
module i2c_target_fsm
  import i2c_reg_target_pkg::*;
#(
  parameter logic [7:0] DEV_BASE = 8'h40,
  parameter logic [7:0] RO_BASE  = 8'hF0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap,
  input  logic       sda_f,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [7:0] reg_rdata,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we
);
  tgt_state_e state_q;
  rx_kind_e   kind_q;
  logic [2:0] bit_q;
  logic [7:0] sh_q, ptr_q, wd_q;
  logic       full_q, rd_q, bump_q, we_q, oe_q, mack_q;
  logic [7:0] wr_match, rd_match;

  assign wr_match = dev_addr(DEV_BASE[7:2], strap, 1'b0);
  assign rd_match = dev_addr(DEV_BASE[7:2], strap, 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= RX_DEV;
      bit_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      wd_q    <= '0;
      full_q  <= 1'b0;
      rd_q    <= 1'b0;
      bump_q  <= 1'b0;
      we_q    <= 1'b0;
      oe_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      bump_q <= 1'b0;
      we_q   <= 1'b0;
      // the pointer moves one cycle after the byte, so the strobe sees the old value
      if (bump_q) ptr_q <= ptr_q + 8'd1;

      if (start_ev) begin
        state_q <= ST_RX;
        kind_q  <= RX_DEV;
        bit_q   <= '0;
        full_q  <= 1'b0;
        oe_q    <= 1'b0;
      end else if (stop_ev) begin
        state_q <= ST_IDLE;
        bit_q   <= '0;
        full_q  <= 1'b0;
        oe_q    <= 1'b0;
      end else begin
        case (state_q)
          ST_RX: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[6:0], sda_f};
              bit_q <= bit_q + 3'd1;
              if (bit_q == 3'd7) full_q <= 1'b1;
            end else if (scl_fall && full_q) begin
              full_q <= 1'b0;
              case (kind_q)
                RX_DEV: begin
                  if (sh_q == wr_match) begin
                    rd_q    <= 1'b0;
                    kind_q  <= RX_SUB;
                    state_q <= ST_ACK;
                    oe_q    <= 1'b1;
                  end else if (sh_q == rd_match) begin
                    rd_q    <= 1'b1;
                    state_q <= ST_ACK;
                    oe_q    <= 1'b1;
                  end else begin
                    state_q <= ST_SKIP;
                  end
                end
                RX_SUB: begin
                  ptr_q   <= sh_q;
                  kind_q  <= RX_DATA;
                  state_q <= ST_ACK;
                  oe_q    <= 1'b1;
                end
                default: begin
                  we_q    <= ~is_read_only(ptr_q, RO_BASE);
                  wd_q    <= sh_q;
                  bump_q  <= 1'b1;
                  state_q <= ST_ACK;
                  oe_q    <= 1'b1;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bit_q <= '0;
              if (rd_q) begin
                state_q <= ST_TX;
                sh_q    <= reg_rdata;
                oe_q    <= ~reg_rdata[7];
              end else begin
                state_q <= ST_RX;
                oe_q    <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_q == 3'd7) begin
                state_q <= ST_MACK;
                oe_q    <= 1'b0;
                bump_q  <= 1'b1;
              end else begin
                sh_q  <= {sh_q[6:0], 1'b0};
                oe_q  <= ~sh_q[6];
                bit_q <= bit_q + 3'd1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_f;
            end else if (scl_fall) begin
              if (mack_q) begin
                state_q <= ST_TX;
                bit_q   <= '0;
                sh_q    <= reg_rdata;
                oe_q    <= ~reg_rdata[7];
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe    = oe_q;
  assign reg_addr  = ptr_q;
  assign reg_wdata = wd_q;
  assign reg_we    = we_q;
endmodule

// File: rtl/i2c_reg_target.sv
`timescale 1ns/1ps
module i2c_reg_target #(
  parameter int         FILT_LEN = 3,
  parameter logic [7:0] DEV_BASE = 8'h40,
  parameter logic [7:0] RO_BASE  = 8'hF0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       addr_sel,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, clean_lines;
  logic scl_f, sda_f;
  logic scl_rise_ev, scl_fall_ev, start_ev, stop_ev;

  assign raw_lines = {sda_i, scl_i};

  generate
    for (genvar g = 0; g < NLINES; g++) begin : g_line
      i2c_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (raw_lines[g]),
        .level (clean_lines[g])
      );
    end
  endgenerate

  assign scl_f = clean_lines[0];
  assign sda_f = clean_lines[1];

  i2c_bus_events u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .scl_rise (scl_rise_ev),
    .scl_fall (scl_fall_ev),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2c_target_fsm #(.DEV_BASE(DEV_BASE), .RO_BASE(RO_BASE)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap     (addr_sel),
    .sda_f     (sda_f),
    .scl_rise  (scl_rise_ev),
    .scl_fall  (scl_fall_ev),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .reg_rdata (reg_rdata),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we)
  );
endmodule

// File: rtl/i2c_reg_target_chk.sv
`timescale 1ns/1ps
module i2c_reg_target_chk #(
  parameter logic [7:0] RO_BASE = 8'hF0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       reg_we,
  input logic [7:0] reg_addr,
  input logic       scl_f,
  input logic       scl_fall_ev,
  input logic       start_ev,
  input logic       stop_ev
);
  p_oe_after_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall_ev || start_ev || stop_ev));

  p_oe_low_scl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_f));

  p_release_cond_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev || stop_ev) |=> !sda_oe);

  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (reg_addr == $past(reg_addr) + 8'd1));

  p_ro_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (reg_addr < RO_BASE));
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.RO_BASE(RO_BASE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sda_oe      (sda_oe),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .scl_f       (scl_f),
  .scl_fall_ev (scl_fall_ev),
  .start_ev    (start_ev),
  .stop_ev     (stop_ev)
);

// File: tb/i2c_reg_target_bench.sv
`timescale 1ns/1ps
module i2c_reg_target_bench;
  localparam int Q = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       addr_sel = 1'b0;
  logic       sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       sda_bus;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_reg_target u_i2c_reg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] init_val(input logic [7:0] a);
    return a * 8'd37 + 8'h5A;
  endfunction
  function automatic logic [7:0] baddr(input logic sel, input logic rd);
    return 8'h40 + (sel ? 8'h02 : 8'h00) + (rd ? 8'h01 : 8'h00);
  endfunction
  function automatic bit ro_b(input logic [7:0] a);
    return a >= 8'hF0;
  endfunction

  // register file model and write log
  logic [7:0] mem [256];
  logic [7:0] log_a [128];
  logic [7:0] log_d [128];
  int log_n = 0;
  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(8'(i));
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      log_a[log_n % 128] <= reg_addr;
      log_d[log_n % 128] <= reg_wdata;
      log_n <= log_n + 1;
    end
  end

  // bus monitors
  logic prev_oe = 1'b0;
  int   bad_drive = 0;
  bit   watch_quiet = 1'b0;
  int   quiet_hits = 0;
  always @(posedge clk) begin
    prev_oe <= sda_oe;
    if (rst_n && sda_oe && !prev_oe && scl_m) bad_drive <= bad_drive + 1;
    if (watch_quiet && sda_oe) quiet_hits <= quiet_hits + 1;
  end

  logic [7:0] exp_mem [256];
  logic [7:0] wbuf [8];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b0; wt(Q / 2);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(Q);
  endtask

  task automatic put_bits(input logic [7:0] b, input int nb, input bit glitch);
    for (int i = 7; i > 7 - nb; i--) begin
      sda_m = b[i]; wt(Q);
      scl_m = 1'b1;
      if (glitch && i == 3) begin
        wt(Q / 2); scl_m = 1'b0; wt(1); scl_m = 1'b1; wt(Q / 2 - 1);
      end else begin
        wt(Q);
      end
      scl_m = 1'b0; wt(Q / 2);
    end
  endtask

  task automatic put_byte(input logic [7:0] b, input bit glitch, output logic ack);
    put_bits(b, 8, glitch);
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q / 2);
    ack = sda_bus; wt(Q / 2);
    scl_m = 1'b0; wt(Q / 2);
  endtask

  task automatic get_byte(input bit nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); scl_m = 1'b1; wt(Q / 2);
      b[i] = sda_bus; wt(Q / 2);
      scl_m = 1'b0; wt(Q / 2);
    end
    sda_m = nack; wt(Q);
    scl_m = 1'b1; wt(Q);
    scl_m = 1'b0; wt(Q / 2);
    sda_m = 1'b1;
  endtask

  task automatic wr_txn(input logic sel, input logic [7:0] sub, input int n,
                        input bit glitch, input string tag);
    logic a;
    int base, e;
    logic [7:0] ak;
    base = log_n;
    addr_sel = sel; wt(4);
    bus_start;
    put_byte(baddr(sel, 1'b0), 1'b0, a);
    chk(a == 1'b0, "R1", "write address ack", a, 0);
    put_byte(sub, 1'b0, a);
    chk(a == 1'b0, "R3", "sub-address ack", a, 0);
    for (int k = 0; k < n; k++) begin
      put_byte(wbuf[k], glitch, a);
      chk(a == 1'b0, tag, "data byte ack", a, 0);
      ak = sub + 8'(k);
      if (!ro_b(ak)) exp_mem[ak] = wbuf[k];
    end
    bus_stop; wt(4);
    e = 0;
    for (int k = 0; k < n; k++) begin
      ak = sub + 8'(k);
      if (!ro_b(ak)) begin
        chk(log_a[(base + e) % 128] == ak, tag, "strobe address", log_a[(base + e) % 128], ak);
        chk(log_d[(base + e) % 128] == wbuf[k], tag, "strobe data", log_d[(base + e) % 128], wbuf[k]);
        e++;
      end
    end
    chk(log_n - base == e, tag, "strobe count", log_n - base, e);
  endtask

  task automatic rd_bytes(input logic [7:0] from, input int n, input string tag);
    logic [7:0] d, ak;
    for (int k = 0; k < n; k++) begin
      get_byte(k == n - 1, d);
      ak = from + 8'(k);
      chk(d == exp_mem[ak], tag, "read byte", d, exp_mem[ak]);
    end
  endtask

  task automatic rd_txn(input logic sel, input logic [7:0] sub, input int n,
                        input bit rep, input string tag);
    logic a;
    addr_sel = sel; wt(4);
    bus_start;
    put_byte(baddr(sel, 1'b0), 1'b0, a);
    put_byte(sub, 1'b0, a);
    if (!rep) bus_stop;
    bus_start;
    put_byte(baddr(sel, 1'b1), 1'b0, a);
    chk(a == 1'b0, "R1", "read address ack", a, 0);
    rd_bytes(sub, n, tag);
    bus_stop; wt(4);
  endtask

  task automatic rd_cont(input logic sel, input logic [7:0] from, input int n,
                         input string tag);
    logic a;
    addr_sel = sel; wt(4);
    bus_start;
    put_byte(baddr(sel, 1'b1), 1'b0, a);
    chk(a == 1'b0, "R1", "read address ack", a, 0);
    rd_bytes(from, n, tag);
    bus_stop; wt(4);
  endtask

  task automatic bad_addr(input logic sel, input logic [7:0] adr);
    logic a;
    int base;
    base = log_n;
    addr_sel = sel; wt(4);
    watch_quiet = 1'b1;
    bus_start;
    put_byte(adr, 1'b0, a);
    chk(a == 1'b1, "R2", "foreign address nack", a, 1);
    put_byte(8'h05, 1'b0, a);
    chk(a == 1'b1, "R2", "ignored byte nack", a, 1);
    put_byte(8'hA7, 1'b0, a);
    chk(a == 1'b1, "R2", "ignored byte nack", a, 1);
    bus_stop; wt(4);
    watch_quiet = 1'b0;
    chk(quiet_hits == 0, "R2", "SDA pulled while ignored", quiet_hits, 0);
    chk(log_n == base, "R2", "strobes while ignored", log_n - base, 0);
  endtask

  initial begin
    logic a;
    logic [7:0] sub;
    int n, base;
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 256; i++) exp_mem[i] = init_val(8'(i));
    wt(5);
    rst_n = 1'b1;
    wt(4);
    chk(sda_oe == 1'b0, "R10", "sda_oe after reset", sda_oe, 0);
    chk(reg_we == 1'b0, "R10", "reg_we after reset", reg_we, 0);
    chk(reg_addr == 8'h00, "R10", "reg_addr after reset", reg_addr, 0);

    // random write then read back, both straps, STOP or repeated START
    for (int it = 0; it < 8; it++) begin
      sub = 8'($urandom_range(0, 8'hE0));
      n = 1 + int'($urandom_range(0, 3));
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      wr_txn(it[0], sub, n, 1'b0, "R3");
      rd_txn(it[0], sub, n, bit'($urandom_range(0, 1)), "R6");
      rd_cont(it[0], sub + 8'(n), 2, "R5");
    end

    // foreign addresses, including the other strap's addresses
    bad_addr(1'b0, 8'h42);
    bad_addr(1'b1, 8'h40);
    bad_addr(1'b0, 8'h44);

    // read-only top of map
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    wr_txn(1'b0, 8'hEF, 3, 1'b0, "R7");
    rd_txn(1'b0, 8'hEF, 3, 1'b0, "R7");
    wr_txn(1'b1, 8'hED, 2, 1'b0, "R7");
    wbuf[0] = 8'h9C; wbuf[1] = 8'h44; wbuf[2] = 8'h01;
    wr_txn(1'b1, 8'hEE, 3, 1'b0, "R7");
    rd_cont(1'b1, 8'hF1, 1, "R7");

    // pointer wrap
    rd_txn(1'b0, 8'hFE, 3, 1'b0, "R4");
    rd_cont(1'b0, 8'h01, 1, "R4");

    // repeated START read
    rd_txn(1'b1, 8'h10, 2, 1'b1, "R8");

    // STOP inside a data byte
    base = log_n;
    addr_sel = 1'b0; wt(4);
    bus_start;
    put_byte(baddr(1'b0, 1'b0), 1'b0, a);
    put_byte(8'h30, 1'b0, a);
    put_bits(8'hFF, 4, 1'b0);
    bus_stop; wt(4);
    chk(sda_oe == 1'b0, "R8", "SDA after abort", sda_oe, 0);
    chk(log_n == base, "R8", "strobes after abort", log_n - base, 0);
    rd_cont(1'b0, 8'h30, 1, "R8");

    // START inside a data byte, then a normal write
    bus_start;
    put_byte(baddr(1'b0, 1'b0), 1'b0, a);
    put_byte(8'h31, 1'b0, a);
    put_bits(8'h00, 5, 1'b0);
    wbuf[0] = 8'h6B;
    wr_txn(1'b0, 8'h32, 1, 1'b0, "R8");

    // SCL glitch inside data bytes
    wbuf[0] = 8'h3C; wbuf[1] = 8'hC3;
    wr_txn(1'b1, 8'h50, 2, 1'b1, "R11");
    rd_txn(1'b1, 8'h50, 2, 1'b0, "R11");

    chk(bad_drive == 0, "R9", "SDA pulled low while SCL high", bad_drive, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    $display("FAIL watchdog: actual %0d expected %0d", 180000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_bad + 1);
    $finish;
  end
endmodule